// File: doc/BRIEF.md
# Internal Data Space Address Mapper

This block sits between a CPU core's operand path and its 256-byte internal data space. Each access carries an 8-bit address, an access kind and a direct/indirect flag. From these the block chooses the storage that answers: the special-function-register file or internal RAM. Working-register references are resolved through the bank picked by two status-word bits. Bit references become a byte address plus a bit position.

A byte or register access completes in the cycle it is presented. Storage is read combinationally on `rdata_i`. A bit write needs two cycles. In the request cycle the block reads the target byte and captures it. In the following cycle it writes back the byte with one bit replaced, and `busy_o` is high during that cycle. New requests are ignored while `busy_o` is high. The register contents behind the special-function select are outside this block.

Top module: `idata_mapper`

## Requirements
- R1: A byte access (`kind_i`=2'b00) with `direct_i`=1 to an address in 80H–FFH asserts `sfr_sel_o` and not `ram_sel_o`, with `mem_addr_o` equal to `addr_i`.
- R2: A byte access with `direct_i`=0 to 80H–FFH asserts `ram_sel_o` and never `sfr_sel_o`, with `mem_addr_o` equal to `addr_i`.
- R3: A byte access to 00H–7FH selects RAM at `addr_i` whatever the value of `direct_i`.
- R4: A register access (`kind_i`=2'b01) selects RAM at byte `bank_i`*8+`reg_num_i`, whatever the value of `direct_i`.
- R5: A bit access (`kind_i`=2'b10) with bit address b in 00H–7FH (taken from `addr_i`) selects RAM byte 20H+(b>>3), at bit position b&7.
- R6: A bit access with b in 80H–FFH selects the special-function byte b&F8H, at bit position b&7.
- R7: A bit read (`we_i`=0) completes in one cycle, with `mem_we_o`=0 and `rdata_o` = {7'b0, `rdata_i`[position]}.
- R8: A bit write (`we_i`=1) reads the target with `mem_we_o`=0 in the request cycle. In the next cycle it raises `busy_o` and `mem_we_o`, keeps the same address and select, and drives `mem_wdata_o` as the captured byte with only the addressed bit replaced by `bit_val_i`.
- R9: While `busy_o` is high, `req_i` and the other request inputs are ignored, and `busy_o` lasts exactly one cycle.
- R10: A byte or register write drives `mem_we_o`=1 and `mem_wdata_o`=`wdata_i` in the same cycle. A byte or register read passes `rdata_i` to `rdata_o`.
- R11: With `req_i`=0, or with the reserved kind 2'b11, and no write-back pending, no select or write is asserted. After reset `busy_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| direct_i | input | 1 | 1 = direct addressing, 0 = indirect |
| kind_i | input | 2 | 00 byte, 01 working register, 10 bit, 11 reserved |
| addr_i | input | 8 | Byte address or bit address |
| reg_num_i | input | 3 | Working register number |
| bank_i | input | 2 | Active bank from status word |
| wdata_i | input | 8 | Byte write data |
| bit_val_i | input | 1 | Value for a bit write |
| rdata_i | input | 8 | Read data from the selected storage |
| ram_sel_o | output | 1 | Internal RAM select |
| sfr_sel_o | output | 1 | Special-function register select |
| mem_addr_o | output | 8 | Byte address to storage |
| mem_we_o | output | 1 | Storage write enable |
| mem_wdata_o | output | 8 | Storage write data |
| rdata_o | output | 8 | Byte read data, or the bit in bit 0 |
| busy_o | output | 1 | Bit write-back in progress |

## Verification
A bit write's write-back cycle and a fresh request can fall in the same cycle. The bench provokes this by holding `req_i` high with a byte write to a different RAM address straight after a bit write. In that cycle it checks that the ports carry only the write-back: the bit byte's address, the merged data and `busy_o`. The held byte write must then appear one cycle later. Read-backs of both bytes judge that neither store was lost or corrupted.

// File: rtl/idata_pkg.sv
package idata_pkg;
  typedef enum logic [1:0] {
    ACC_BYTE = 2'b00,
    ACC_REG  = 2'b01,
    ACC_BIT  = 2'b10,
    ACC_RSVD = 2'b11
  } acc_kind_e;
endpackage

// File: rtl/idata_bank_map.sv
module idata_bank_map #(
  parameter int unsigned ADDR_W        = 8,
  parameter int unsigned REGS_PER_BANK = 8,
  parameter int unsigned NUM_BANKS     = 4,
  localparam int unsigned REG_W  = $clog2(REGS_PER_BANK),
  localparam int unsigned BANK_W = $clog2(NUM_BANKS)
) (
  input  logic [BANK_W-1:0] bank_i,
  input  logic [REG_W-1:0]  reg_i,
  output logic [ADDR_W-1:0] addr_o
);
  always_comb begin
    addr_o = ADDR_W'(bank_i) * ADDR_W'(REGS_PER_BANK) + ADDR_W'(reg_i);
  end
endmodule

// File: rtl/idata_bit_map.sv
module idata_bit_map #(
  parameter int unsigned ADDR_W        = 8,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned BIT_BYTE_BASE = 32,
  localparam int unsigned POS_W = $clog2(DATA_W)
) (
  input  logic [ADDR_W-1:0] bit_addr_i,
  output logic [ADDR_W-1:0] byte_addr_o,
  output logic [POS_W-1:0]  pos_o,
  output logic              sfr_o
);
  always_comb begin
    pos_o = bit_addr_i[POS_W-1:0];
    sfr_o = bit_addr_i[ADDR_W-1];
    if (sfr_o) begin
      // upper bit space: aligned register byte
      byte_addr_o = {bit_addr_i[ADDR_W-1:POS_W], {POS_W{1'b0}}};
    end else begin
      byte_addr_o = ADDR_W'(BIT_BYTE_BASE) + (bit_addr_i >> POS_W);
    end
  end
endmodule

// File: rtl/idata_rmw.sv
module idata_rmw #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned POS_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              sfr_i,
  input  logic [POS_W-1:0]  pos_i,
  input  logic              bit_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              sfr_o,
  output logic [DATA_W-1:0] wdata_o
);
  logic              busy_q;
  logic [ADDR_W-1:0] addr_q;
  logic              sfr_q;
  logic [POS_W-1:0]  pos_q;
  logic              bit_q;
  logic [DATA_W-1:0] byte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      addr_q <= '0;
      sfr_q  <= 1'b0;
      pos_q  <= '0;
      bit_q  <= 1'b0;
      byte_q <= '0;
    end else begin
      busy_q <= start_i & ~busy_q;
      if (start_i && !busy_q) begin
        addr_q <= addr_i;
        sfr_q  <= sfr_i;
        pos_q  <= pos_i;
        bit_q  <= bit_i;
        byte_q <= rdata_i;
      end
    end
  end

  for (genvar g = 0; g < DATA_W; g++) begin : g_merge
    assign wdata_o[g] = (pos_q == POS_W'(g)) ? bit_q : byte_q[g];
  end

  assign busy_o = busy_q;
  assign addr_o = addr_q;
  assign sfr_o  = sfr_q;

  p_busy_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> !busy_q);
  p_wb_after_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_q) |=> busy_q);
endmodule

// File: rtl/idata_mapper.sv
module idata_mapper #(
  parameter int unsigned ADDR_W        = 8,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned REGS_PER_BANK = 8,
  parameter int unsigned NUM_BANKS     = 4,
  parameter int unsigned BIT_BYTES     = 16,
  localparam int unsigned REG_W     = $clog2(REGS_PER_BANK),
  localparam int unsigned BANK_W    = $clog2(NUM_BANKS),
  localparam int unsigned POS_W     = $clog2(DATA_W),
  localparam int unsigned BANK_SPAN = REGS_PER_BANK * NUM_BANKS,
  localparam int unsigned BIT_BASE  = BANK_SPAN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              direct_i,
  input  logic [1:0]        kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  reg_num_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              bit_val_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              ram_sel_o,
  output logic              sfr_sel_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              busy_o
);
  import idata_pkg::*;

  acc_kind_e         kind;
  logic [ADDR_W-1:0] reg_addr;
  logic [ADDR_W-1:0] bit_byte;
  logic [POS_W-1:0]  bit_pos;
  logic              bit_sfr;
  logic              busy;
  logic [ADDR_W-1:0] wb_addr;
  logic              wb_sfr;
  logic [DATA_W-1:0] wb_data;
  logic              accept;
  logic              dec_valid;
  logic              dec_sfr;
  logic [ADDR_W-1:0] dec_addr;
  logic              start_bw;

  assign kind = acc_kind_e'(kind_i);

  idata_bank_map #(
    .ADDR_W(ADDR_W), .REGS_PER_BANK(REGS_PER_BANK), .NUM_BANKS(NUM_BANKS)
  ) u_bank_map (
    .bank_i(bank_i), .reg_i(reg_num_i), .addr_o(reg_addr)
  );

  idata_bit_map #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BIT_BYTE_BASE(BIT_BASE)
  ) u_bit_map (
    .bit_addr_i(addr_i), .byte_addr_o(bit_byte), .pos_o(bit_pos), .sfr_o(bit_sfr)
  );

  always_comb begin
    dec_valid = 1'b1;
    dec_sfr   = 1'b0;
    dec_addr  = addr_i;
    unique case (kind)
      ACC_BYTE: dec_sfr = direct_i & addr_i[ADDR_W-1];
      ACC_REG:  dec_addr = reg_addr;
      ACC_BIT: begin
        dec_addr = bit_byte;
        dec_sfr  = bit_sfr;
      end
      default:  dec_valid = 1'b0;
    endcase
  end

  assign accept   = req_i & ~busy & dec_valid;
  assign start_bw = accept & (kind == ACC_BIT) & we_i;

  idata_rmw #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_rmw (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_bw),
    .addr_i(dec_addr), .sfr_i(dec_sfr), .pos_i(bit_pos), .bit_i(bit_val_i),
    .rdata_i(rdata_i), .busy_o(busy), .addr_o(wb_addr), .sfr_o(wb_sfr),
    .wdata_o(wb_data)
  );

  always_comb begin
    ram_sel_o   = 1'b0;
    sfr_sel_o   = 1'b0;
    mem_addr_o  = '0;
    mem_we_o    = 1'b0;
    mem_wdata_o = '0;
    if (busy) begin
      ram_sel_o   = ~wb_sfr;
      sfr_sel_o   = wb_sfr;
      mem_addr_o  = wb_addr;
      mem_we_o    = 1'b1;
      mem_wdata_o = wb_data;
    end else if (accept) begin
      ram_sel_o   = ~dec_sfr;
      sfr_sel_o   = dec_sfr;
      mem_addr_o  = dec_addr;
      mem_we_o    = we_i & (kind != ACC_BIT);
      mem_wdata_o = wdata_i;
    end
  end

  assign rdata_o = (accept && kind == ACC_BIT) ? DATA_W'(rdata_i[bit_pos]) : rdata_i;
  assign busy_o  = busy;

  p_sel_excl_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ram_sel_o && sfr_sel_o));
  p_ind_no_sfr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o && kind_i == 2'b00 && !direct_i) |-> (ram_sel_o && !sfr_sel_o));
  p_reg_bank_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o && kind_i == 2'b01) |-> (ram_sel_o && mem_addr_o < ADDR_W'(BANK_SPAN)));
  p_bit_window_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o && kind_i == 2'b10 && !addr_i[ADDR_W-1]) |->
    (ram_sel_o && mem_addr_o >= ADDR_W'(BIT_BASE) && mem_addr_o < ADDR_W'(BIT_BASE + BIT_BYTES)));
  p_bit_no_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o && kind_i == 2'b10) |-> !mem_we_o);
  p_wb_addr_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (mem_we_o && mem_addr_o == $past(mem_addr_o)));
  p_wb_one_bit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> ($countones(mem_wdata_o ^ $past(rdata_i)) <= 1));
  p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_i && !busy_o) |-> (!ram_sel_o && !sfr_sel_o && !mem_we_o));
endmodule

// File: tb/idata_mapper_bench.sv
module idata_mapper_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0, we = 1'b0, direct = 1'b0, bit_val = 1'b0;
  logic [1:0] kind = 2'b00;
  logic [7:0] addr = '0, wdata = '0;
  logic [2:0] reg_num = '0;
  logic [1:0] bank = '0;
  logic [7:0] rdata_mem;
  logic       ram_sel, sfr_sel, mem_we, busy;
  logic [7:0] mem_addr, mem_wdata, rdata;
  int         n_chk = 0, n_fail = 0;
  logic [7:0] ram [256];
  logic [7:0] sfr [256];

  always #2 clk = ~clk;

  idata_mapper u_idata_mapper (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .direct_i(direct),
    .kind_i(kind), .addr_i(addr), .reg_num_i(reg_num), .bank_i(bank),
    .wdata_i(wdata), .bit_val_i(bit_val), .rdata_i(rdata_mem),
    .ram_sel_o(ram_sel), .sfr_sel_o(sfr_sel), .mem_addr_o(mem_addr),
    .mem_we_o(mem_we), .mem_wdata_o(mem_wdata), .rdata_o(rdata), .busy_o(busy)
  );

  assign rdata_mem = ram_sel ? ram[mem_addr] : (sfr_sel ? sfr[mem_addr] : 8'h00);

  always @(posedge clk) begin
    if (mem_we && ram_sel) ram[mem_addr] <= mem_wdata;
    if (mem_we && sfr_sel) sfr[mem_addr] <= mem_wdata;
  end

  task automatic chk(input string rq, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic put(input logic [1:0] k, input logic d, input logic w, input logic [7:0] a,
                     input logic [7:0] wd, input logic bv);
    @(negedge clk);
    req = 1'b1; kind = k; direct = d; we = w; addr = a; wdata = wd; bit_val = bv;
    #1;
  endtask

  task automatic put_reg(input logic [1:0] b, input logic [2:0] r, input logic d);
    @(negedge clk);
    req = 1'b1; kind = 2'b01; direct = d; we = 1'b0; bank = b; reg_num = r;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    chk("R11", "busy after reset", {7'b0, busy}, 8'h00);
    chk("R11", "sel after reset", {6'b0, ram_sel, sfr_sel}, 8'h00);
    chk("R11", "we after reset", {7'b0, mem_we}, 8'h00);
  endtask

  task automatic t_direct_upper();
    put(2'b00, 1'b1, 1'b0, 8'h90, 8'h00, 1'b0);
    chk("R1", "sel 90 direct", {6'b0, ram_sel, sfr_sel}, 8'h01);
    chk("R1", "addr 90 direct", mem_addr, 8'h90);
    chk("R1", "rdata 90 direct", rdata, 8'h6F);
    put(2'b00, 1'b1, 1'b1, 8'h99, 8'hA5, 1'b0);
    chk("R10", "byte write we", {7'b0, mem_we}, 8'h01);
    chk("R10", "byte write data", mem_wdata, 8'hA5);
    put(2'b00, 1'b1, 1'b0, 8'h99, 8'h00, 1'b0);
    chk("R1", "sfr 99 readback", rdata, 8'hA5);
    idle();
  endtask

  task automatic t_indirect_upper();
    put(2'b00, 1'b0, 1'b0, 8'h90, 8'h00, 1'b0);
    chk("R2", "sel 90 indirect", {6'b0, ram_sel, sfr_sel}, 8'h02);
    chk("R2", "rdata 90 indirect", rdata, 8'hCA);
    put(2'b00, 1'b0, 1'b1, 8'h99, 8'h3C, 1'b0);
    put(2'b00, 1'b0, 1'b0, 8'h99, 8'h00, 1'b0);
    chk("R2", "ram 99 readback", rdata, 8'h3C);
    put(2'b00, 1'b1, 1'b0, 8'h99, 8'h00, 1'b0);
    chk("R2", "sfr 99 untouched", rdata, 8'hA5);
    idle();
  endtask

  task automatic t_lower();
    put(2'b00, 1'b1, 1'b0, 8'h45, 8'h00, 1'b0);
    chk("R3", "45 direct sel", {6'b0, ram_sel, sfr_sel}, 8'h02);
    chk("R3", "45 direct data", rdata, 8'h1F);
    put(2'b00, 1'b0, 1'b0, 8'h7F, 8'h00, 1'b0);
    chk("R3", "7F indirect sel", {6'b0, ram_sel, sfr_sel}, 8'h02);
    chk("R3", "7F indirect addr", mem_addr, 8'h7F);
    idle();
  endtask

  task automatic t_regs();
    put_reg(2'd2, 3'd5, 1'b1);
    chk("R4", "bank2 r5 addr", mem_addr, 8'h15);
    chk("R4", "bank2 r5 sel", {6'b0, ram_sel, sfr_sel}, 8'h02);
    put_reg(2'd3, 3'd7, 1'b0);
    chk("R4", "bank3 r7 addr", mem_addr, 8'h1F);
    chk("R4", "bank3 r7 data", rdata, 8'h45);
    put_reg(2'd0, 3'd0, 1'b1);
    chk("R4", "bank0 r0 addr", mem_addr, 8'h00);
    idle();
  endtask

  task automatic t_bit_read();
    put(2'b10, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0);
    chk("R5", "bit 00 byte", mem_addr, 8'h20);
    chk("R7", "bit 00 value", rdata, 8'h00);
    put(2'b10, 1'b1, 1'b0, 8'h7F, 8'h00, 1'b0);
    chk("R5", "bit 7F byte", mem_addr, 8'h2F);
    chk("R7", "bit 7F value", rdata, 8'h00);
    put(2'b10, 1'b0, 1'b0, 8'h3B, 8'h00, 1'b0);
    chk("R5", "bit 3B byte", mem_addr, 8'h27);
    chk("R7", "bit 3B value", rdata, 8'h01);
    chk("R7", "bit read no write", {7'b0, mem_we}, 8'h00);
    put(2'b10, 1'b0, 1'b0, 8'h8C, 8'h00, 1'b0);
    chk("R6", "bit 8C sel", {6'b0, ram_sel, sfr_sel}, 8'h01);
    chk("R6", "bit 8C byte", mem_addr, 8'h88);
    chk("R6", "bit 8C value", rdata, 8'h01);
    idle();
  endtask

  task automatic t_bit_write();
    put(2'b10, 1'b0, 1'b1, 8'h3B, 8'h00, 1'b0);
    chk("R8", "rmw read we", {7'b0, mem_we}, 8'h00);
    chk("R8", "rmw read addr", mem_addr, 8'h27);
    idle();
    chk("R8", "rmw busy", {7'b0, busy}, 8'h01);
    chk("R8", "rmw wb we", {7'b0, mem_we}, 8'h01);
    chk("R8", "rmw wb addr", mem_addr, 8'h27);
    chk("R8", "rmw wb data", mem_wdata, 8'h75);
    idle();
    chk("R9", "busy one cycle", {7'b0, busy}, 8'h00);
    put(2'b00, 1'b0, 1'b0, 8'h27, 8'h00, 1'b0);
    chk("R8", "byte 27 after rmw", rdata, 8'h75);
    put(2'b10, 1'b1, 1'b1, 8'h8C, 8'h00, 1'b0);
    idle();
    chk("R8", "sfr wb sel", {6'b0, ram_sel, sfr_sel}, 8'h01);
    put(2'b00, 1'b1, 1'b0, 8'h88, 8'h00, 1'b0);
    chk("R6", "sfr 88 after rmw", rdata, 8'h67);
    idle();
  endtask

  task automatic t_collide();
    put(2'b10, 1'b0, 1'b1, 8'h00, 8'h00, 1'b1);
    put(2'b00, 1'b0, 1'b1, 8'h30, 8'hEE, 1'b0);
    chk("R9", "collide busy", {7'b0, busy}, 8'h01);
    chk("R9", "collide addr is wb", mem_addr, 8'h20);
    chk("R9", "collide data is wb", mem_wdata, 8'h7B);
    @(negedge clk); #1;
    chk("R9", "held req addr", mem_addr, 8'h30);
    chk("R10", "held req data", mem_wdata, 8'hEE);
    put(2'b00, 1'b0, 1'b0, 8'h20, 8'h00, 1'b0);
    chk("R9", "bit byte kept", rdata, 8'h7B);
    put(2'b00, 1'b0, 1'b0, 8'h30, 8'h00, 1'b0);
    chk("R9", "held byte stored", rdata, 8'hEE);
    idle();
  endtask

  task automatic t_quiet();
    put(2'b11, 1'b1, 1'b1, 8'h90, 8'h55, 1'b0);
    chk("R11", "reserved kind sel", {6'b0, ram_sel, sfr_sel}, 8'h00);
    chk("R11", "reserved kind we", {7'b0, mem_we}, 8'h00);
    idle();
    chk("R11", "idle sel", {6'b0, ram_sel, sfr_sel}, 8'h00);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      ram[i] = 8'(i) ^ 8'h5A;
      sfr[i] = ~8'(i);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_direct_upper();
    t_indirect_upper();
    t_lower();
    t_regs();
    t_bit_read();
    t_bit_write();
    t_collide();
    t_quiet();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule